// File: doc/BRIEF.md
# Quad Cascadable Gated Timer

Four 16-bit up-counters share one 16-bit global control word, so a single register write can start, stop, freeze-protect or join any mix of them. Each counter advances on a prescaled count-enable pulse, compares itself against its own limit value and, when it passes that limit, restarts from zero and raises a sticky event flag. Neighbouring counters can be joined in pairs into 32-bit counters. Each pair has an active-low gate input that can switch counting on and off, either restarting the count on every gate opening or resuming where it left off.

Software reaches the block through a flat synchronous register port: a 4-bit address, a write strobe, 32-bit write data and combinational read data. A stopped counter keeps its registers readable and writable, so software can preload a count while counting is halted and then release it.

Top module: `qtmr_top`

## Requirements
- R1: After reset every register reads zero. Register map: 0 global control (bits 15:0), 1 gate-enable bits (bit n-1 for timer n), 2 event flags (bit n-1 for timer n), 4..7 limit of timers 1..4, 8..11 count of timers 1..4; a non-joined access uses data bits 15:0.
- R2: Enable bits sit at control bits 0, 4, 8, 12 for timers 1..4; with its enable bit 0 a timer's count and event flag are held at zero and count writes are ignored, and with the enable bit 1 and its stop bit 0 the count rises by one per tick.
- R3: Stop bits sit at control bits 1, 5, 9, 13; a set stop bit halts counting while count writes and reads keep working, and clearing it resumes from the held value.
- R4: Freeze-response bits sit at control bits 2, 6, 10, 14; with the bit set the timer does not count while the freeze input is high, with it clear the freeze input has no effect.
- R5: On a counting tick while the count equals the limit, the count becomes zero and the event flag sets, so the count after N ticks from zero is N mod (limit+1); writing 1 to a flag bit clears it, writing 0 leaves it, and a new wrap wins over a clear.
- R6: Join bit 7 makes timers 1 and 2 one 32-bit counter and join bit 15 does the same for timers 3 and 4; the lower-numbered timer holds the upper half, the upper half steps only when the lower half rolls over from all ones, the limit compare is 32 bits wide, the pair obeys only the lower-numbered timer's enable, stop, freeze and gate-enable bits, and its wrap sets the lower-numbered timer's flag.
- R7: While a pair is joined, the limit and count addresses of its lower-numbered timer read and write the whole 32-bit value, upper half in data bits 31:16.
- R8: A gated timer counts only while its pair's gate is open; the pin is sampled each clock, the edge that sees a high-to-low change opens the gate and the edge that sees a low-to-high change closes it, counting happens on the edges after the opening edge up to and including the closing edge.
- R9: Gate-mode bit 3 (pair 1) and bit 11 (pair 2) at 0 select restart mode, where the opening edge clears the count of each gated timer of the pair; at 1 the opening edge keeps the count.
- R10: A timer whose gate-enable bit is 0 ignores its pair's gate pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe, registered at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| tick | input | 1 | Prescaled count enable |
| freeze | input | 1 | Halt request for freeze-responsive timers |
| gate_n | input | 2 | Active-low gate pins, bit 0 for timers 1/2, bit 1 for timers 3/4 |

## Verification
Assertions check every cycle that a held timer reads zero, that stop and freeze keep an unjoined count unchanged, that a wrap leaves zero with the flag set, that a joined pair carries into its upper half, that a restart-mode opening clears the count, and that the gate state follows the pin edges. The bench scenarios are what show the arithmetic end to end: the modulo sweep over several limits, the 32-bit values seen through the joined addresses, the exact edge count of a gate window, and that ungated or non-responsive timers keep counting.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;
  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_GATE = 4'd1;
  localparam logic [3:0] A_FLAG = 4'd2;
  localparam logic [3:0] A_REF  = 4'd4;
  localparam logic [3:0] A_CNT  = 4'd8;
  localparam int CTRL_W = 16;
  localparam int N_PAIR = 2;
  localparam int N_TMR  = 2 * N_PAIR;

  // One byte of the global control word; 'a' is the lower-numbered timer.
  typedef struct packed {
    logic cas;
    logic frz_b;
    logic stp_b;
    logic en_b;
    logic gm;
    logic frz_a;
    logic stp_a;
    logic en_a;
  } pair_ctl_t;
endpackage

// File: rtl/qtmr_gate.sv
module qtmr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall,
  output logic open
);
  logic prev_q;
  logic rise;

  assign fall = prev_q & ~pin_n;
  assign rise = ~prev_q & pin_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      open   <= 1'b0;
    end else begin
      prev_q <= pin_n;
      if (fall)      open <= 1'b1;
      else if (rise) open <= 1'b0;
    end
  end

  p_gate_open_r8: assert property (@(posedge clk) disable iff (!rst_n) fall |=> open);
  p_gate_close_r8: assert property (@(posedge clk) disable iff (!rst_n) rise |=> !open);
endmodule

// File: rtl/qtmr_pair.sv
module qtmr_pair
  import qtmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pair_ctl_t         ctl,
  input  logic [1:0]        gate_en,
  input  logic              gate_open,
  input  logic              gate_fall,
  input  logic              freeze,
  input  logic              tick,
  input  logic [1:0][W-1:0] ref_v,
  input  logic [1:0]        cnt_we,
  input  logic [1:0][W-1:0] cnt_wd,
  input  logic [1:0]        flag_clr,
  output logic [1:0][W-1:0] cnt,
  output logic [1:0]        flag
);
  localparam int PW = 2 * W;

  function automatic logic [W-1:0] step_one(input logic [W-1:0] c, input logic [W-1:0] r);
    return (c == r) ? '0 : c + 1'b1;
  endfunction

  function automatic logic [PW-1:0] step_two(input logic [PW-1:0] c, input logic [PW-1:0] r);
    return (c == r) ? '0 : c + 1'b1;
  endfunction

  logic [1:0] en, stp, frz, gated;
  logic [1:0] hold, restart, adv, hit, wrap;
  logic [1:0][W-1:0] nxt;

  // Effective per-half controls: a joined pair follows timer 'a' only.
  always_comb begin
    en    = {ctl.en_b, ctl.en_a};
    stp   = {ctl.stp_b, ctl.stp_a};
    frz   = {ctl.frz_b, ctl.frz_a};
    gated = gate_en;
    if (ctl.cas) begin
      en    = {2{ctl.en_a}};
      stp   = {2{ctl.stp_a}};
      frz   = {2{ctl.frz_a}};
      gated = {2{gate_en[0]}};
    end
  end

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      hold[k]    = ~en[k];
      restart[k] = gate_fall & ~ctl.gm & gated[k];
      adv[k]     = tick & en[k] & ~stp[k] & ~(frz[k] & freeze) & (~gated[k] | gate_open);
    end
  end

  always_comb begin
    if (ctl.cas) begin
      {nxt[0], nxt[1]} = step_two({cnt[0], cnt[1]}, {ref_v[0], ref_v[1]});
      hit = {1'b0, {cnt[0], cnt[1]} == {ref_v[0], ref_v[1]}};
    end else begin
      nxt[0] = step_one(cnt[0], ref_v[0]);
      nxt[1] = step_one(cnt[1], ref_v[1]);
      hit    = {cnt[1] == ref_v[1], cnt[0] == ref_v[0]};
    end
  end

  assign wrap = adv & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= '0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (hold[k]) begin
          cnt[k]  <= '0;
          flag[k] <= 1'b0;
        end else begin
          if (cnt_we[k])       cnt[k] <= cnt_wd[k];
          else if (restart[k]) cnt[k] <= '0;
          else if (adv[k])     cnt[k] <= nxt[k];
          if (wrap[k])          flag[k] <= 1'b1;
          else if (flag_clr[k]) flag[k] <= 1'b0;
        end
      end
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hold[0] |=> (cnt[0] == '0) && !flag[0]);
  p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.cas && ctl.en_a && ctl.stp_a && !cnt_we[0] && !restart[0]) |=> $stable(cnt[0]));
  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.cas && ctl.en_a && ctl.frz_a && freeze && !cnt_we[0] && !restart[0]) |=> $stable(cnt[0]));
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.cas && wrap[1] && !cnt_we[1]) |=> (cnt[1] == '0) && flag[1]);
  p_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.cas && adv[1] && !wrap[0] && (cnt[1] == '1) && (cnt_we == 2'b00) && !restart[1])
    |=> (cnt[1] == '0) && (cnt[0] == W'($past(cnt[0]) + 1'b1)));
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (restart[0] && !hold[0] && !cnt_we[0]) |=> (cnt[0] == '0));
endmodule

// File: rtl/qtmr_top.sv
module qtmr_top
  import qtmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      bus_addr,
  input  logic            bus_we,
  input  logic [2*W-1:0]  bus_wdata,
  output logic [2*W-1:0]  bus_rdata,
  input  logic            tick,
  input  logic            freeze,
  input  logic [1:0]      gate_n
);
  localparam int DW = 2 * W;

  logic [CTRL_W-1:0]            ctrl_q;
  logic [N_TMR-1:0]             gen_q;
  logic [N_TMR-1:0][W-1:0]      ref_q;
  logic [N_TMR-1:0][W-1:0]      cnt_all;
  logic [N_TMR-1:0][W-1:0]      cnt_wd;
  logic [N_TMR-1:0]             cnt_we;
  logic [N_TMR-1:0]             flags;
  logic [N_TMR-1:0]             flag_clr;
  logic [N_TMR-1:0]             ref_hit, cnt_hit;
  logic [N_PAIR-1:0]            cas;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      gen_q  <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (bus_addr == A_GATE) gen_q  <= bus_wdata[N_TMR-1:0];
    end
  end

  assign flag_clr = (bus_we && bus_addr == A_FLAG) ? bus_wdata[N_TMR-1:0] : '0;

  genvar t;
  generate
    for (t = 0; t < N_TMR; t++) begin : g_tmr
      localparam int P = t / 2;
      assign ref_hit[t] = bus_we && (bus_addr == A_REF + 4'(t));
      assign cnt_hit[t] = bus_we && (bus_addr == A_CNT + 4'(t));
      if (t % 2 == 0) begin : g_upper
        assign cnt_we[t] = cnt_hit[t];
        assign cnt_wd[t] = cas[P] ? bus_wdata[DW-1:W] : bus_wdata[W-1:0];
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)          ref_q[t] <= '0;
          else if (ref_hit[t]) ref_q[t] <= cas[P] ? bus_wdata[DW-1:W] : bus_wdata[W-1:0];
        end
      end else begin : g_lower
        assign cnt_we[t] = cnt_hit[t] || (cas[P] && cnt_hit[t-1]);
        assign cnt_wd[t] = bus_wdata[W-1:0];
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ref_q[t] <= '0;
          else if (ref_hit[t] || (cas[P] && ref_hit[t-1])) ref_q[t] <= bus_wdata[W-1:0];
        end
      end
    end
  endgenerate

  genvar p;
  generate
    for (p = 0; p < N_PAIR; p++) begin : g_pair
      logic      g_fall, g_open;
      pair_ctl_t ctl;
      assign ctl    = pair_ctl_t'(ctrl_q[8*p +: 8]);
      assign cas[p] = ctl.cas;

      qtmr_gate i_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (gate_n[p]),
        .fall  (g_fall),
        .open  (g_open)
      );

      qtmr_pair #(.W(W)) i_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .gate_en   (gen_q[2*p +: 2]),
        .gate_open (g_open),
        .gate_fall (g_fall),
        .freeze    (freeze),
        .tick      (tick),
        .ref_v     (ref_q[2*p +: 2]),
        .cnt_we    (cnt_we[2*p +: 2]),
        .cnt_wd    (cnt_wd[2*p +: 2]),
        .flag_clr  (flag_clr[2*p +: 2]),
        .cnt       (cnt_all[2*p +: 2]),
        .flag      (flags[2*p +: 2])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) bus_rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
    if (bus_addr == A_GATE) bus_rdata = {{(DW-N_TMR){1'b0}}, gen_q};
    if (bus_addr == A_FLAG) bus_rdata = {{(DW-N_TMR){1'b0}}, flags};
    for (int k = 0; k < N_PAIR; k++) begin
      if (bus_addr == A_REF + 4'(2*k))
        bus_rdata = cas[k] ? {ref_q[2*k], ref_q[2*k+1]} : {{W{1'b0}}, ref_q[2*k]};
      if (bus_addr == A_REF + 4'(2*k+1))
        bus_rdata = {{W{1'b0}}, ref_q[2*k+1]};
      if (bus_addr == A_CNT + 4'(2*k))
        bus_rdata = cas[k] ? {cnt_all[2*k], cnt_all[2*k+1]} : {{W{1'b0}}, cnt_all[2*k]};
      if (bus_addr == A_CNT + 4'(2*k+1))
        bus_rdata = {{W{1'b0}}, cnt_all[2*k+1]};
    end
  end

  p_ctrl_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CTRL) |=> ctrl_q == $past(bus_wdata[CTRL_W-1:0]));
endmodule

// File: tb/test_qtmr_top.sv
`timescale 1ns/1ps
module test_qtmr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick = 1'b0;
  logic        freeze = 1'b0;
  logic [1:0]  gate_n = 2'b11;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  qtmr_top i_qtmr_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .freeze(freeze), .gate_n(gate_n)
  );

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a;
    #0.1;
    n_cmp++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr %0d: actual %h expected %h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic run(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of every register
    chk("R1", 4'd0, 0); chk("R1", 4'd1, 0); chk("R1", 4'd2, 0);
    for (int a = 4; a < 12; a++) chk("R1", 4'(a), 0);
    // R2: disabled timers stay at zero
    run(3);
    for (int a = 8; a < 12; a++) chk("R2", 4'(a), 0);
    for (int a = 4; a < 8; a++) wr(4'(a), 32'h0000_FFFF);
    // R2: sweep, one timer enabled at a time
    for (int k = 0; k < 4; k++) begin
      wr(4'd0, 0);
      wr(4'd0, 32'(1 << (4*k)));
      run(k + 3);
      for (int j = 0; j < 4; j++) chk("R2", 4'(8 + j), (j == k) ? 32'(k + 3) : 0);
    end
    // R3: stop keeps the count and register access
    wr(4'd0, 0); wr(4'd0, 32'h0001);
    run(4); chk("R3", 4'd8, 4);
    wr(4'd0, 32'h0003);
    run(5); chk("R3", 4'd8, 4);
    wr(4'd8, 32'h1234); chk("R3", 4'd8, 32'h1234);
    wr(4'd0, 32'h0001);
    run(2); chk("R3", 4'd8, 32'h1236);
    // R4: freeze response only where enabled
    wr(4'd0, 0); wr(4'd0, 32'h0015);
    freeze = 1'b1;
    run(4); chk("R4", 4'd8, 0); chk("R4", 4'd9, 4);
    freeze = 1'b0;
    run(3); chk("R4", 4'd8, 3); chk("R4", 4'd9, 7);
    // R5: wrap arithmetic over several limits on timer 3
    for (int i = 0; i < 7; i++) begin
      int r;
      r = (i == 6) ? 20 : i;
      wr(4'd0, 0);
      wr(4'd6, 32'(r));
      wr(4'd0, 32'h0100);
      run(13);
      chk("R5", 4'd10, 32'(13 % (r + 1)));
      chk("R5", 4'd2, (13 > r) ? 32'h4 : 0);
    end
    wr(4'd0, 0); wr(4'd6, 32'd2); wr(4'd0, 32'h0100);
    run(3); chk("R5", 4'd2, 32'h4);
    wr(4'd2, 32'h0); chk("R5", 4'd2, 32'h4);
    wr(4'd2, 32'h4); chk("R5", 4'd2, 0);
    // R6/R7: joined pair 1, timer 2's own bits left at zero
    wr(4'd0, 0);
    wr(4'd0, 32'h0083);
    wr(4'd4, 32'h0001_0002); chk("R7", 4'd4, 32'h0001_0002); chk("R7", 4'd5, 32'h0002);
    wr(4'd8, 32'h0000_FFFD); chk("R7", 4'd8, 32'h0000_FFFD);
    wr(4'd0, 32'h0081);
    run(3); chk("R6", 4'd8, 32'h0001_0000); chk("R7", 4'd9, 0);
    run(2); chk("R6", 4'd8, 32'h0001_0002); chk("R6", 4'd2, 0);
    run(1); chk("R6", 4'd8, 0); chk("R6", 4'd2, 32'h1);
    // R6: joined pair 2 carry
    wr(4'd0, 32'h8300);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd10, 32'h0002_FFFF);
    wr(4'd0, 32'h8100);
    run(1); chk("R6", 4'd10, 32'h0003_0000);
    // R8-R10: gate on pair 1, timer 1 gated, timer 2 not
    wr(4'd0, 0);
    wr(4'd4, 32'hFFFF); wr(4'd5, 32'hFFFF);
    wr(4'd1, 32'h1);
    wr(4'd0, 32'h0011);
    tick = 1'b1;
    begin
      logic [31:0] c2;
      bus_addr = 4'd9; #0.1; c2 = bus_rdata;
      repeat (4) @(negedge clk);
      chk("R10", 4'd9, c2 + 4);
    end
    chk("R8", 4'd8, 0);
    wr(4'd8, 32'd50); chk("R8", 4'd8, 50);
    gate_n[0] = 1'b0;
    @(negedge clk); chk("R9", 4'd8, 0);
    repeat (5) @(negedge clk); chk("R8", 4'd8, 5);
    gate_n[0] = 1'b1;
    repeat (3) @(negedge clk); chk("R8", 4'd8, 6);
    wr(4'd0, 32'h0019); chk("R8", 4'd8, 6);
    gate_n[0] = 1'b0;
    repeat (5) @(negedge clk); chk("R9", 4'd8, 10);
    tick = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule